// File: doc/BRIEF.md
# Asynchronous Memory Bus Timing Controller

This block turns single read and write requests from the chip interior into cycles on an asynchronous external memory bus. It drives a 26-bit address, a 16-bit data path toward a bidirectional pad, an address-valid strobe, a chip enable, an output enable and a write enable. Every access walks through three phases: address setup, then address hold, then data setup. A write adds one more clock after data setup. Each phase length is a count of system clock cycles taken from a small register file.

Two timing sets exist. The primary set times all reads, and also times writes when the extended-write switch is off. When that switch is on, writes use the secondary set. The timing set is captured when a request is accepted, so a register write during an access only affects later accesses.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle, and a request transfers on a clock edge where both `req_valid` and `req_ready` are high. Holding `req_valid` high while busy does nothing. The completion side has no back-pressure: `rsp_valid` is a one-cycle pulse and the requester must take it when it comes.

Top module: `asyncmem_timing_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, all four strobes are high, `mem_dq_oe`=0 and `rsp_valid`=0. `req_ready` is high exactly while idle. A request presented while busy is ignored; the address and write data of the running access do not change.
- R2: The register file has two registers. `cfg_sel`=0 selects the primary register, laid out as address setup in bits 3:0, address hold in bits 7:4, data setup in bits 15:8 and the extended-write switch in bit 16. `cfg_sel`=1 selects the write register, which uses the same positions for bits 15:0. Both registers reset to zero.
- R3: An access starts in the cycle after acceptance. It runs address setup for max(S,1) cycles, then address hold for H cycles (skipped when H=0), then data setup for max(D,1) cycles, where S, H and D are the selected fields.
- R4: `mem_ce_n` is low for every cycle of an access. `mem_adv_n` is low only during address setup, and no other strobe or data drive is active then. `mem_addr` holds the accepted address for the whole access.
- R5: On a read, `mem_oe_n` is low during address hold and data setup, and `mem_we_n` stays high. `mem_dq_in` is sampled at the clock edge that ends the last data-setup cycle, and that value appears on `rsp_rdata`.
- R6: On a write, `mem_we_n` is low during data setup and `mem_oe_n` stays high. One extra cycle follows data setup. `mem_dq_out` carries the accepted write data and `mem_dq_oe` is high from the start of data setup to the end of the extra cycle, and low at all other times.
- R7: With the extended-write switch set, writes take their timing from the write register. Reads always use the primary register. With the switch clear, writes also use the primary register.
- R8: `rsp_valid` is high for exactly one cycle: the first idle cycle after an access ends. `req_ready` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = primary register, 1 = write register |
| cfg_wdata | input | 17 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Request address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data returned by the last read |
| mem_addr | output | 26 | External address |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 16 | Data toward the bidirectional pad |
| mem_dq_oe | output | 1 | Pad output enable for the data bus |
| mem_dq_in | input | 16 | Data from the bidirectional pad |

## Verification
The bench sweeps the three fields over both directions and both settings of the extended-write switch. The sweep includes zero fields, a 15-cycle setup and a 255-cycle data setup. Every strobe is compared in every cycle of every access against a phase map computed from the field values. A design that failed to clamp a zero to one clock, or that did not skip a zero hold, would show a strobe shifted by a cycle. The memory model changes the read data in every cycle, so a design that sampled one cycle early or late returns the wrong word. A request presented mid-access with a different address exposes a controller that re-latches while busy. Pairing different primary and write register values exposes a design that picks the wrong timing set.

// File: rtl/amb_pkg.sv
package amb_pkg;
  localparam int ASET_W = 4;
  localparam int AHLD_W = 4;
  localparam int DSET_W = 8;

  typedef struct packed {
    logic [DSET_W-1:0] dset;
    logic [AHLD_W-1:0] ahld;
    logic [ASET_W-1:0] aset;
  } timing_t;

  localparam int TIM_W   = $bits(timing_t);
  localparam int EXT_BIT = TIM_W;
  localparam int CFG_W   = TIM_W + 1;
  localparam int CNT_W   = DSET_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ASET,
    PH_AHLD,
    PH_DSET,
    PH_WEXT
  } phase_e;
endpackage

// File: rtl/amb_timing_regs.sv
module amb_timing_regs
  import amb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output timing_t          rd_tim,
  output timing_t          wr_tim,
  output logic             ext_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_tim <= '0;
      wr_tim <= '0;
      ext_en <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        rd_tim <= timing_t'(cfg_wdata[TIM_W-1:0]);
        ext_en <= cfg_wdata[EXT_BIT];
      end else begin
        wr_tim <= timing_t'(cfg_wdata[TIM_W-1:0]);
      end
    end
  end
endmodule

// File: rtl/amb_phase_seq.sv
module amb_phase_seq
  import amb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    start_wr,
  input  timing_t start_tim,
  output phase_e  phase,
  output logic    is_wr,
  output logic    last_cycle,
  output logic    done
);
  logic [CNT_W-1:0] cnt_q;
  timing_t          tim_q;

  function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  assign last_cycle = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
      tim_q <= '0;
      is_wr <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ASET;
            cnt_q <= len_m1(CNT_W'(start_tim.aset));
            tim_q <= start_tim;
            is_wr <= start_wr;
          end
        end
        PH_ASET: begin
          if (!last_cycle) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (tim_q.ahld != '0) begin
            phase <= PH_AHLD;
            cnt_q <= len_m1(CNT_W'(tim_q.ahld));
          end else begin
            phase <= PH_DSET;
            cnt_q <= len_m1(CNT_W'(tim_q.dset));
          end
        end
        PH_AHLD: begin
          if (!last_cycle) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            phase <= PH_DSET;
            cnt_q <= len_m1(CNT_W'(tim_q.dset));
          end
        end
        PH_DSET: begin
          if (!last_cycle) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (is_wr) begin
            phase <= PH_WEXT;
            cnt_q <= '0;
          end else begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        PH_WEXT: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amb_bus_drive.sv
module amb_bus_drive
  import amb_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_e            phase,
  input  logic              is_wr,
  input  logic              last_cycle,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_adv_n,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] rdata
);
  logic in_hold, in_data, sample;

  assign in_hold = (phase == PH_AHLD);
  assign in_data = (phase == PH_DSET);
  assign sample  = in_data && last_cycle && !is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rdata      <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (sample) begin
        rdata <= mem_dq_in;
      end
    end
  end

  assign mem_adv_n = (phase != PH_ASET);
  assign mem_ce_n  = (phase == PH_IDLE);
  assign mem_oe_n  = !(!is_wr && (in_hold || in_data));
  assign mem_we_n  = !(is_wr && in_data);
  assign mem_dq_oe = is_wr && (in_data || phase == PH_WEXT);
endmodule

// File: rtl/asyncmem_timing_ctrl.sv
module asyncmem_timing_ctrl
  import amb_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_adv_n,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  timing_t rd_tim, wr_tim, sel_tim;
  logic    ext_en, accept, is_wr, last_cycle;
  phase_e  phase;

  amb_timing_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_tim(rd_tim), .wr_tim(wr_tim), .ext_en(ext_en)
  );

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign sel_tim   = (req_write && ext_en) ? wr_tim : rd_tim;

  amb_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
    .start_tim(sel_tim), .phase(phase), .is_wr(is_wr),
    .last_cycle(last_cycle), .done(rsp_valid)
  );

  amb_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .phase(phase), .is_wr(is_wr),
    .last_cycle(last_cycle), .mem_dq_in(mem_dq_in), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_adv_n(mem_adv_n),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .rdata(rsp_rdata)
  );
endmodule

// File: rtl/amb_ctrl_checker.sv
module amb_ctrl_checker #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_adv_n,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);
  assert_idle_ce_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  assert_start_with_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> !mem_adv_n);

  assert_adv_within_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_ce_n);

  assert_adv_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (req_ready || $stable(mem_addr)));

  assert_oe_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  assert_we_with_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

bind asyncmem_timing_ctrl amb_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/asyncmem_timing_ctrl_bench.sv
`timescale 1ns/1ps
module asyncmem_timing_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [25:0] req_addr = '0, mem_addr;
  logic [15:0] req_wdata = '0, rsp_rdata, mem_dq_out, mem_dq_in = '0;
  logic        rsp_valid, mem_adv_n, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  int          n_cmp = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  asyncmem_timing_ctrl u_asyncmem_timing_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // R2: primary register {ext[16], dset[15:8], ahld[7:4], aset[3:0]}
  task automatic set_cfg(input logic sel, input logic ext, input int a, input int h, input int d);
    cfg_we = 1'b1; cfg_sel = sel;
    cfg_wdata = {ext, 8'(d), 4'(h), 4'(a)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access; a/h/d are the fields the controller should be using.
  task automatic run_access(input logic wr, input logic [25:0] addr,
                            input logic [15:0] wd, input int a, input int h, input int d);
    int al, dl, total, ph;
    al = (a == 0) ? 1 : a;
    dl = (d == 0) ? 1 : d;
    total = al + h + dl + (wr ? 1 : 0);
    check("R1 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    for (int k = 0; k < total; k++) begin
      ph = (k < al) ? 1 : (k < al + h) ? 2 : (k < al + h + dl) ? 3 : 4;
      // R3 R4 R5 R6: strobe vector {adv_n, ce_n, oe_n, we_n, dq_oe}
      check(wr ? "R6 write strobes" : "R5 read strobes",
            32'({mem_adv_n, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}),
            32'({(ph != 1), 1'b0, !(!wr && (ph == 2 || ph == 3)),
                 !(wr && ph == 3), (wr && ph >= 3)}));
      check("R1 busy not ready", 32'(req_ready), 32'd0);
      check("R4 address held", 32'(mem_addr), 32'(addr));
      check("R8 no early done", 32'(rsp_valid), 32'd0);
      if (wr && ph >= 3) check("R6 write data", 32'(mem_dq_out), 32'(wd));
      if (k == 0) begin
        req_addr = addr ^ 26'h2AAAAAA;   // R1 decoy while busy
        req_wdata = ~wd;
      end else begin
        req_valid = 1'b0;
      end
      mem_dq_in = addr[15:0] ^ 16'(k * 257);
      @(negedge clk);
    end
    check("R8 done pulse", 32'(rsp_valid), 32'd1);
    check("R8 ready with done", 32'(req_ready), 32'd1);
    check("R3 access length", 32'(mem_ce_n), 32'd1);
    if (!wr) check("R5 read data", 32'(rsp_rdata), 32'(addr[15:0] ^ 16'((total - 1) * 257)));
    @(negedge clk);
    check("R8 single-cycle done", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    summary();
  end

  initial begin
    int av[4] = '{0, 1, 2, 15};
    int hv[3] = '{0, 1, 3};
    int dv[3] = '{0, 1, 3};
    int wa, wh, wdd, n;
    repeat (3) @(negedge clk);
    check("R1 reset ready", 32'(req_ready), 32'd1);
    check("R1 reset strobes", 32'({mem_adv_n, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}),
          32'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'({mem_ce_n, req_ready}), 32'b11);
    // R2: reset values are zero -> timing 1/0/1 for both directions
    run_access(1'b0, 26'h0000123, 16'h0, 0, 0, 0);
    run_access(1'b1, 26'h0000456, 16'hBEEF, 0, 0, 0);
    n = 0;
    for (int e = 0; e < 2; e++)
      for (int ia = 0; ia < 4; ia++)
        for (int ih = 0; ih < 3; ih++)
          for (int id = 0; id < 3; id++) begin
            wa = (av[ia] + 3) % 16; wh = (hv[ih] + 2) % 16; wdd = dv[id] + 2;
            set_cfg(1'b0, e[0], av[ia], hv[ih], dv[id]);
            set_cfg(1'b1, 1'b0, wa, wh, wdd);
            n++;
            // R7: reads always on primary fields
            run_access(1'b0, 26'(n * 40503 + 7), 16'h0, av[ia], hv[ih], dv[id]);
            // R7: writes on write register only when the switch is set
            if (e == 1) run_access(1'b1, 26'(n * 9973 + 3), 16'(n * 777), wa, wh, wdd);
            else        run_access(1'b1, 26'(n * 9973 + 3), 16'(n * 777), av[ia], hv[ih], dv[id]);
          end
    // R3: longest fields
    set_cfg(1'b0, 1'b1, 15, 15, 255);
    set_cfg(1'b1, 1'b0, 0, 0, 255);
    run_access(1'b0, 26'h3FFFFFF, 16'h0, 15, 15, 255);
    run_access(1'b1, 26'h2000001, 16'hA55A, 0, 0, 255);
    summary();
  end
endmodule